// File: doc/BRIEF.md
# PPP Octet Escape Mapper

This block sits between a frame source and a byte-wide line interface for PPP running over octet-synchronous or start/stop links. In the transmit direction it takes one frame at a time and puts a flag byte (0x7E) before it and another after it. The frame arrives as a valid/ready byte stream with a last marker, and the CRC has already been appended upstream. Any byte in the configured escape set is replaced by the control-escape byte 0x7D followed by the original byte with bit 5 inverted (XOR 0x20).

In the receive direction it takes the raw line byte stream and does the reverse. It uses flags to find frame boundaries and removes escape bytes, restoring the byte that follows each one. It drops unescaped control characters that the map selects. Each frame is delivered as a valid/ready stream with a last marker on its final byte and an abort marker when the sender cancelled the frame. CRC checking is left to a neighbouring block.

The escape set is the union of several sources. The bytes 0x7E and 0x7D are always in it. A 32-bit map selects any of the bytes 0x00 to 0x1F, with bit n for byte n. A number of extra byte values, each with its own enable, can also be added.

Top module: `ppp_octet_mapper`

## Requirements
- R1: After reset both output streams are idle (tx_out_valid and rx_out_valid low) and tx_in_ready is low until the opening flag of a frame has been offered.
- R2: A transmitted frame appears on tx_out as 0x7E, then the encoded payload bytes in input order, then 0x7E. A new frame starts with its own opening flag.
- R3: A payload byte b in 0x00..0x1F whose bit b of cfg_accm is 1 is sent as 0x7D followed by b XOR 0x20. If the bit is 0 the byte is sent unchanged.
- R4: Payload bytes 0x7E and 0x7D are always sent as 0x7D followed by 0x5E and 0x5D respectively, whatever the map says.
- R5: A payload byte equal to extra slot i (cfg_extra bits 8i+7..8i) is escaped when cfg_extra_en bit i is 1. A disabled slot has no effect.
- R6: While tx_out_valid is high and tx_out_ready is low, tx_out_valid stays high and tx_out_data keeps its value.
- R7: On receive, 0x7D is removed and the following byte is delivered XORed with 0x20.
- R8: On receive, an unescaped byte in 0x00..0x1F whose map bit is set is discarded.
- R9: On receive, the byte before a closing flag is delivered with rx_out_last high. Bytes before the first flag after reset, and frames with no data bytes, produce no output.
- R10: On receive, 0x7D directly followed by 0x7E ends the frame: its last data byte is delivered with both rx_out_last and rx_out_abort high.
- R11: While rx_out_valid is high and rx_out_ready is low, the receive outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_accm | input | 32 | Escape map for bytes 0x00..0x1F |
| cfg_extra | input | 8*N_EXTRA | Extra escape byte values, slot i in bits 8i+7..8i |
| cfg_extra_en | input | N_EXTRA | Enable per extra slot |
| tx_in_valid | input | 1 | Transmit payload byte valid |
| tx_in_data | input | 8 | Transmit payload byte |
| tx_in_last | input | 1 | Marks the final payload byte of a frame |
| tx_in_ready | output | 1 | Transmit payload byte accepted |
| tx_out_valid | output | 1 | Line byte valid |
| tx_out_data | output | 8 | Encoded line byte |
| tx_out_ready | input | 1 | Line side accepts byte |
| rx_in_valid | input | 1 | Received line byte valid |
| rx_in_data | input | 8 | Received line byte |
| rx_in_ready | output | 1 | Received line byte accepted |
| rx_out_valid | output | 1 | Decoded byte valid |
| rx_out_data | output | 8 | Decoded byte |
| rx_out_last | output | 1 | Final byte of the frame |
| rx_out_abort | output | 1 | Frame ended by abort sequence |
| rx_out_ready | input | 1 | Consumer accepts decoded byte |

## Verification
The bench builds the block with N_EXTRA = 4. This makes three enabled extra slots and one disabled slot possible in the same frame, and lets one extra slot overlap the control range so that it escapes a byte the map leaves clear. Both ready inputs follow fixed stall patterns throughout the run, so escape pairs, flags and closing bytes are all exercised under back-pressure. The receive streams include leading garbage, empty frames, shared flags and an abort sequence.

// File: rtl/ppp_octet_mapper.sv
module ppp_octet_mapper #(
  parameter int N_EXTRA = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          cfg_accm,
  input  logic [8*N_EXTRA-1:0] cfg_extra,
  input  logic [N_EXTRA-1:0]   cfg_extra_en,
  input  logic                 tx_in_valid,
  input  logic [7:0]           tx_in_data,
  input  logic                 tx_in_last,
  output logic                 tx_in_ready,
  output logic                 tx_out_valid,
  output logic [7:0]           tx_out_data,
  input  logic                 tx_out_ready,
  input  logic                 rx_in_valid,
  input  logic [7:0]           rx_in_data,
  output logic                 rx_in_ready,
  output logic                 rx_out_valid,
  output logic [7:0]           rx_out_data,
  output logic                 rx_out_last,
  output logic                 rx_out_abort,
  input  logic                 rx_out_ready
);

  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] ESC  = 8'h7D;
  localparam logic [7:0] FLIP = 8'h20;

  typedef enum logic [1:0] {T_IDLE, T_DATA, T_ESC, T_CLOSE} tx_state_t;

  tx_state_t    tx_st;
  logic [7:0]   tx_hold;
  logic         tx_hold_last;
  logic [N_EXTRA-1:0] extra_hit;
  logic         tx_esc;

  for (genvar g = 0; g < N_EXTRA; g++) begin : g_extra
    assign extra_hit[g] = cfg_extra_en[g] && (cfg_extra[g*8 +: 8] == tx_in_data);
  end

  assign tx_esc = (tx_in_data == FLAG) || (tx_in_data == ESC) ||
                  ((tx_in_data < 8'h20) && cfg_accm[tx_in_data[4:0]]) || (|extra_hit);

  always_comb begin
    tx_out_valid = 1'b0;
    tx_out_data  = FLAG;
    tx_in_ready  = 1'b0;
    case (tx_st)
      T_IDLE:  tx_out_valid = tx_in_valid;
      T_DATA: begin
        tx_out_valid = tx_in_valid;
        tx_out_data  = tx_esc ? ESC : tx_in_data;
        tx_in_ready  = tx_out_ready;
      end
      T_ESC: begin
        tx_out_valid = 1'b1;
        tx_out_data  = tx_hold;
      end
      default: tx_out_valid = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st        <= T_IDLE;
      tx_hold      <= '0;
      tx_hold_last <= 1'b0;
    end else begin
      case (tx_st)
        T_IDLE: if (tx_in_valid && tx_out_ready) tx_st <= T_DATA;
        T_DATA: if (tx_in_valid && tx_out_ready) begin
          if (tx_esc) begin
            tx_hold      <= tx_in_data ^ FLIP;
            tx_hold_last <= tx_in_last;
            tx_st        <= T_ESC;
          end else if (tx_in_last) begin
            tx_st <= T_CLOSE;
          end
        end
        T_ESC:   if (tx_out_ready) tx_st <= tx_hold_last ? T_CLOSE : T_DATA;
        default: if (tx_out_ready) tx_st <= T_IDLE;
      endcase
    end
  end

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data));

  assert_tx_escpair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && tx_out_ready && tx_in_ready && tx_in_valid && tx_out_data == ESC
    |=> tx_out_valid && tx_out_data == ($past(tx_in_data) ^ FLIP));

  logic       rx_inf, rx_escp, rx_hold_vld;
  logic [7:0] rx_hold;
  logic       rx_acc, rx_ctrl;

  assign rx_in_ready = !rx_out_valid || rx_out_ready;
  assign rx_acc      = rx_in_valid && rx_in_ready;
  assign rx_ctrl     = (rx_in_data < 8'h20) && cfg_accm[rx_in_data[4:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_inf       <= 1'b0;
      rx_escp      <= 1'b0;
      rx_hold_vld  <= 1'b0;
      rx_hold      <= '0;
      rx_out_valid <= 1'b0;
      rx_out_data  <= '0;
      rx_out_last  <= 1'b0;
      rx_out_abort <= 1'b0;
    end else begin
      if (rx_out_valid && rx_out_ready) rx_out_valid <= 1'b0;
      if (rx_acc) begin
        if (rx_in_data == FLAG) begin
          rx_inf      <= 1'b1;
          rx_escp     <= 1'b0;
          rx_hold_vld <= 1'b0;
          if (rx_hold_vld) begin
            rx_out_valid <= 1'b1;
            rx_out_data  <= rx_hold;
            rx_out_last  <= 1'b1;
            rx_out_abort <= rx_escp;
          end
        end else if (rx_inf) begin
          if (rx_in_data == ESC) begin
            rx_escp <= 1'b1;
          end else if (rx_escp || !rx_ctrl) begin
            rx_escp     <= 1'b0;
            rx_hold     <= rx_escp ? (rx_in_data ^ FLIP) : rx_in_data;
            rx_hold_vld <= 1'b1;
            if (rx_hold_vld) begin
              rx_out_valid <= 1'b1;
              rx_out_data  <= rx_hold;
              rx_out_last  <= 1'b0;
              rx_out_abort <= 1'b0;
            end
          end
        end
      end
    end
  end

  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid &&
    $stable({rx_out_data, rx_out_last, rx_out_abort}));

  assert_rx_abort_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && rx_out_abort |-> rx_out_last);

endmodule

// File: tb/ppp_octet_mapper_tb.sv
`timescale 1ns/1ps
module ppp_octet_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_accm = '0;
  logic [31:0] cfg_extra = '0;
  logic [3:0]  cfg_extra_en = '0;
  logic        tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_out_ready = 1'b0;
  logic [7:0]  tx_in_data = '0;
  logic        tx_in_ready, tx_out_valid;
  logic [7:0]  tx_out_data;
  logic        rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0]  rx_in_data = '0;
  logic        rx_in_ready, rx_out_valid, rx_out_last, rx_out_abort;
  logic [7:0]  rx_out_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] src_q[$];
  logic [9:0] rexp_q[$];

  always #2 clk = ~clk;

  ppp_octet_mapper #(.N_EXTRA(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_accm(cfg_accm), .cfg_extra(cfg_extra),
    .cfg_extra_en(cfg_extra_en), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
    .tx_in_last(tx_in_last), .tx_in_ready(tx_in_ready), .tx_out_valid(tx_out_valid),
    .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready), .rx_in_valid(rx_in_valid),
    .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready), .rx_out_valid(rx_out_valid),
    .rx_out_data(rx_out_data), .rx_out_last(rx_out_last), .rx_out_abort(rx_out_abort),
    .rx_out_ready(rx_out_ready));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic tb_esc(input logic [7:0] b);
    logic hit = (b == 8'h7E) || (b == 8'h7D) || (b < 8'h20 && cfg_accm[b[4:0]]);
    for (int i = 0; i < 4; i++) if (cfg_extra_en[i] && cfg_extra[i*8 +: 8] == b) hit = 1'b1;
    return hit;
  endfunction

  task automatic tx_run(input string tag);
    logic [7:0] exp[$];
    logic [7:0] got[$];
    int idx = 0, cyc = 0;
    exp.push_back(8'h7E);
    foreach (src_q[i]) begin
      if (tb_esc(src_q[i])) begin exp.push_back(8'h7D); exp.push_back(src_q[i] ^ 8'h20); end
      else exp.push_back(src_q[i]);
    end
    exp.push_back(8'h7E);
    while (got.size() < exp.size() && cyc < 2000) begin
      @(negedge clk); cyc++;
      tx_out_ready = (cyc % 3) != 1;
      if (idx < src_q.size()) begin
        tx_in_valid = 1'b1; tx_in_data = src_q[idx]; tx_in_last = (idx == src_q.size() - 1);
      end else begin
        tx_in_valid = 1'b0; tx_in_last = 1'b0;
      end
      #1;
      if (tx_in_valid && tx_in_ready) idx++;
      if (tx_out_valid && tx_out_ready) got.push_back(tx_out_data);
    end
    @(negedge clk); tx_in_valid = 1'b0; tx_in_last = 1'b0; tx_out_ready = 1'b0;
    check(tag, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++) check(tag, got[i], exp[i]);
  endtask

  task automatic rx_run(input string tag);
    logic [9:0] got[$];
    int idx = 0, cyc = 0, idle = 0;
    while ((idx < src_q.size() || idle < 8) && cyc < 3000) begin
      @(negedge clk); cyc++;
      rx_out_ready = (cyc % 4) != 2;
      rx_in_valid = idx < src_q.size();
      rx_in_data  = (idx < src_q.size()) ? src_q[idx] : 8'h00;
      #1;
      if (rx_in_valid && rx_in_ready) idx++;
      if (idx >= src_q.size()) idle++;
      if (rx_out_valid && rx_out_ready) got.push_back({rx_out_abort, rx_out_last, rx_out_data});
    end
    @(negedge clk); rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    check(tag, got.size(), rexp_q.size());
    for (int i = 0; i < rexp_q.size() && i < got.size(); i++) check(tag, got[i], rexp_q[i]);
  endtask

  task automatic t_reset;
    #1;
    check("R1 tx_out_valid", tx_out_valid, 0);
    check("R1 rx_out_valid", rx_out_valid, 0);
    check("R1 tx_in_ready", tx_in_ready, 0);
  endtask

  task automatic t_tx_stall;
    logic [7:0] got[$];
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_data = 8'h41; tx_in_last = 1'b1; tx_out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R6 valid", tx_out_valid, 1);
      check("R6 data", tx_out_data, 8'h7E);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tx_out_ready = 1'b1; #1;
      if (tx_out_valid) got.push_back(tx_out_data);
      if (tx_in_ready && tx_in_valid) begin
        @(negedge clk); tx_in_valid = 1'b0; tx_in_last = 1'b0; #1;
        if (tx_out_valid) got.push_back(tx_out_data);
      end
    end
    tx_out_ready = 1'b0;
    check("R6 count", got.size(), 3);
    if (got.size() == 3) begin
      check("R6 b0", got[0], 8'h7E); check("R6 b1", got[1], 8'h41); check("R6 b2", got[2], 8'h7E);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    src_q = '{8'h42};                          tx_run("R2 single");
    src_q = '{8'h01, 8'h41, 8'h7E, 8'h7D, 8'h55}; tx_run("R4 fixed");
    cfg_accm = 32'h0000_000A;
    src_q = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h1F}; tx_run("R3 map");
    cfg_accm = 32'h0;
    cfg_extra = {8'h33, 8'h80, 8'hFF, 8'h11}; cfg_extra_en = 4'b0111;
    src_q = '{8'h11, 8'hFF, 8'h80, 8'h33, 8'h12}; tx_run("R5 extra");
    cfg_extra_en = 4'b0000;
    t_tx_stall();
    // R9: 0x55 and 0x33 precede the first flag and must be dropped
    src_q  = '{8'h55, 8'h33, 8'h7E, 8'h41, 8'h7D, 8'h5E, 8'h7D, 8'h5D, 8'h7D, 8'h21, 8'h42, 8'h7E};
    rexp_q = '{10'h041, 10'h07E, 10'h07D, 10'h001, 10'h142};
    rx_run("R7 R9 R11");
    cfg_accm = 32'h0000_000A;
    src_q  = '{8'h7E, 8'h01, 8'h41, 8'h03, 8'h02, 8'h7E};
    rexp_q = '{10'h041, 10'h102};
    rx_run("R8");
    cfg_accm = 32'h0;
    src_q  = '{8'h7E, 8'h7E, 8'h61, 8'h62, 8'h7D, 8'h7E, 8'h63, 8'h7E, 8'h7E};
    rexp_q = '{10'h061, 10'h362, 10'h163};
    rx_run("R10");
    src_q  = '{8'h7E, 8'h7E, 8'h7E, 8'h44, 8'h7E};
    rexp_q = '{10'h144};
    rx_run("R9 empty");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule